// File: doc/BRIEF.md
# Misaligned Load/Store Access Splitter

This block sits between a load/store issue stage and a data memory port that is one doubleword (eight bytes) wide. It takes one request at a time: an effective address, an operand size, a load/store flag, right-justified store data, a byte-reverse flag and a multiple-word flag. It turns that request into one or two doubleword-aligned memory accesses with byte enables. When a load needs two accesses, it merges the returned bytes into one right-justified result.

An operand that fits inside one aligned doubleword takes a single access. An operand that crosses a doubleword boundary takes two accesses: the lower doubleword first, then the next one. Each access returns a translation status with its acknowledge. A TLB miss makes the block repeat the same portion until translation succeeds, so the miss looks like a stall. A page fault ends the request. On the first portion it reports a fault. On the second portion it reports a restart, and the caller issues the whole request again.

Top module: `lss_split_unit`

## Requirements
- R1: An operand whose bytes all lie in one 8-byte-aligned doubleword takes exactly one memory access, and `done` pulses in the cycle after that access is acknowledged with translation ok.
- R2: An operand with offset + size > 8 takes two accesses in order. The first goes to the aligned doubleword that holds the start address. The second goes to that address plus 8. `done` pulses in the cycle after the second ok acknowledge.
- R3: Memory is big-endian. `mem_be[b]` enables `mem_wdata[8b+7:8b]`, and byte offset o within the doubleword maps to byte b = 7-o. Store data is taken right-justified from `req_wdata`, and only the operand's bytes are enabled.
- R4: A load result appears right-justified on `rsp_rdata` while `done` is high. Bits above the operand are zero.
- R5: With `req_rev` set, the byte order of the operand is reversed: before placement for a store, and after the merge for a load.
- R6: `mem_xlat` = 1 (TLB miss) on an acknowledge makes the block reissue the same portion with the same address and enables in the next cycle. The request still ends with `done` and no restart.
- R7: `mem_xlat` = 2 (page fault) on the second portion ends the request with a one-cycle `rsp_restart` and no `done`. A store's first half has already been written, and a retry writes it again.
- R8: `mem_xlat` = 2 on the first portion ends the request with a one-cycle `rsp_fault`, and the second portion is never issued.
- R9: A request with `req_multi` set and `req_addr[1:0]` nonzero makes no memory access. `rsp_align_exc` pulses in the cycle after acceptance. Word-aligned multiple-word requests proceed normally.
- R10: `req_ready` is high only when no request is in progress. Every accepted request ends with exactly one one-cycle pulse on one of `done`, `rsp_restart`, `rsp_fault` or `rsp_align_exc`.
- R11: After reset, `req_ready` is 1, and `mem_req` and all end pulses are 0.

Size code `req_size`: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 bytes. Translation code: 0 = ok, 1 = TLB miss, 2 = page fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | ADDR_W | Effective byte address |
| req_size | input | 2 | Operand size code |
| req_store | input | 1 | 1 = store, 0 = load |
| req_rev | input | 1 | Byte-reversed variant |
| req_multi | input | 1 | Multiple-word request (word alignment needed) |
| req_wdata | input | 8*LANES | Right-justified store operand |
| mem_req | output | 1 | Memory access request |
| mem_ack | input | 1 | Access acknowledged, status on mem_xlat |
| mem_addr | output | ADDR_W | Doubleword-aligned access address |
| mem_we | output | 1 | Write access |
| mem_be | output | LANES | Byte enables |
| mem_wdata | output | 8*LANES | Write data lanes |
| mem_rdata | input | 8*LANES | Read data, valid with mem_ack |
| mem_xlat | input | 2 | Translation status with mem_ack |
| done | output | 1 | Request completed |
| rsp_rdata | output | 8*LANES | Load result, right-justified |
| rsp_restart | output | 1 | Second portion page-faulted, reissue request |
| rsp_fault | output | 1 | First portion page-faulted |
| rsp_align_exc | output | 1 | Misaligned multiple-word request |

## Verification
The bench builds the block with ADDR_W = 16 and LANES = 8. This gives the real doubleword lane count, so every offset and size pair, and every split point from one spilled byte to seven, can be reached inside a 64-byte model memory. The memory model follows a per-request script of translation codes. That lets misses, first-portion faults and second-portion faults be placed on exactly the portion each requirement names. After every store, the model memory is compared byte for byte with a reference built from the requirement text.

// File: rtl/lss_pkg.sv
package lss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } lss_state_e;

    localparam logic [1:0] XL_OK    = 2'd0;
    localparam logic [1:0] XL_MISS  = 2'd1;
    localparam logic [1:0] XL_FAULT = 2'd2;
endpackage

// File: rtl/lss_byte_swap.sv
module lss_byte_swap #(
    parameter int LANES = 8,
    localparam int DW    = 8 * LANES,
    localparam int NB_W  = $clog2(LANES) + 1
) (
    input  logic [DW-1:0]   din,
    input  logic [NB_W-1:0] nbytes,
    output logic [DW-1:0]   dout
);
    always_comb begin
        dout = '0;
        for (int b = 0; b < LANES; b++) begin
            if (b < int'(nbytes)) begin
                dout[8*b +: 8] = 8'(din >> (8 * (int'(nbytes) - 1 - b)));
            end
        end
    end
endmodule

// File: rtl/lss_lane_calc.sv
module lss_lane_calc #(
    parameter int LANES = 8,
    localparam int DW    = 8 * LANES,
    localparam int OFF_W = $clog2(LANES),
    localparam int NB_W  = OFF_W + 1
) (
    input  logic [OFF_W-1:0] off,
    input  logic [NB_W-1:0]  nbytes,
    input  logic [DW-1:0]    oper,
    output logic [LANES-1:0] be_lo,
    output logic [LANES-1:0] be_hi,
    output logic [DW-1:0]    wd_lo,
    output logic [DW-1:0]    wd_hi,
    output logic             split
);
    logic [DW-1:0]      left_just;
    logic [2*DW-1:0]    data_win;
    logic [LANES-1:0]   lead_mask;
    logic [2*LANES-1:0] mask_win;

    always_comb begin
        left_just = oper << (8 * (LANES - int'(nbytes)));
        data_win  = {left_just, {DW{1'b0}}} >> (8 * int'(off));
        lead_mask = ~({LANES{1'b1}} >> nbytes);
        mask_win  = {lead_mask, {LANES{1'b0}}} >> off;
        wd_lo     = data_win[2*DW-1:DW];
        wd_hi     = data_win[DW-1:0];
        be_lo     = mask_win[2*LANES-1:LANES];
        be_hi     = mask_win[LANES-1:0];
        split     = |mask_win[LANES-1:0];
    end
endmodule

// File: rtl/lss_load_align.sv
module lss_load_align #(
    parameter int LANES = 8,
    localparam int DW    = 8 * LANES,
    localparam int OFF_W = $clog2(LANES),
    localparam int NB_W  = OFF_W + 1
) (
    input  logic [DW-1:0]    word_lo,
    input  logic [DW-1:0]    word_hi,
    input  logic [OFF_W-1:0] off,
    input  logic [NB_W-1:0]  nbytes,
    output logic [DW-1:0]    result
);
    logic [2*DW-1:0] joined;

    always_comb begin
        joined = {word_lo, word_hi} << (8 * int'(off));
        result = DW'(joined >> (2 * DW - 8 * int'(nbytes)));
    end
endmodule

// File: rtl/lss_split_unit.sv
module lss_split_unit
    import lss_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    localparam int DW    = 8 * LANES,
    localparam int OFF_W = $clog2(LANES),
    localparam int NB_W  = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_store,
    input  logic              req_rev,
    input  logic              req_multi,
    input  logic [DW-1:0]     req_wdata,
    output logic              mem_req,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [LANES-1:0]  mem_be,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [1:0]        mem_xlat,
    output logic              done,
    output logic [DW-1:0]     rsp_rdata,
    output logic              rsp_restart,
    output logic              rsp_fault,
    output logic              rsp_align_exc
);
    typedef struct packed {
        lss_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [NB_W-1:0]   nb;
        logic              store;
        logic              rev;
        logic [DW-1:0]     oper;
        logic [DW-1:0]     first_word;
        logic [DW-1:0]     res;
        logic              done;
        logic              restart;
        logic              fault;
        logic              alx;
    } lss_regs_t;

    lss_regs_t q, d;

    logic [NB_W-1:0]  req_nb;
    logic [DW-1:0]    req_swapped;
    logic [LANES-1:0] be_lo, be_hi;
    logic [DW-1:0]    wd_lo, wd_hi;
    logic             split;
    logic [DW-1:0]    merge_lo, merge_hi;
    logic [DW-1:0]    merged, merged_swapped, load_res;
    logic [ADDR_W-1:0] base_addr;

    assign req_nb = NB_W'(1) << req_size;

    lss_byte_swap #(.LANES(LANES)) u_store_swap (
        .din    (req_wdata),
        .nbytes (req_nb),
        .dout   (req_swapped)
    );

    lss_lane_calc #(.LANES(LANES)) u_lanes (
        .off    (q.addr[OFF_W-1:0]),
        .nbytes (q.nb),
        .oper   (q.oper),
        .be_lo  (be_lo),
        .be_hi  (be_hi),
        .wd_lo  (wd_lo),
        .wd_hi  (wd_hi),
        .split  (split)
    );

    assign merge_lo = (q.st == ST_HI) ? q.first_word : mem_rdata;
    assign merge_hi = (q.st == ST_HI) ? mem_rdata : '0;

    lss_load_align #(.LANES(LANES)) u_align (
        .word_lo (merge_lo),
        .word_hi (merge_hi),
        .off     (q.addr[OFF_W-1:0]),
        .nbytes  (q.nb),
        .result  (merged)
    );

    lss_byte_swap #(.LANES(LANES)) u_load_swap (
        .din    (merged),
        .nbytes (q.nb),
        .dout   (merged_swapped)
    );

    assign load_res  = q.rev ? merged_swapped : merged;
    assign base_addr = {q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.restart = 1'b0;
        d.fault   = 1'b0;
        d.alx     = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_multi && (req_addr[1:0] != 2'b00)) begin
                        d.alx = 1'b1;
                    end else begin
                        d.st    = ST_LO;
                        d.addr  = req_addr;
                        d.nb    = req_nb;
                        d.store = req_store;
                        d.rev   = req_rev;
                        d.oper  = req_rev ? req_swapped : req_wdata;
                    end
                end
            end
            ST_LO: begin
                if (mem_ack) begin
                    if (mem_xlat == XL_OK) begin
                        if (split) begin
                            d.st         = ST_HI;
                            d.first_word = mem_rdata;
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            d.res  = q.store ? '0 : load_res;
                        end
                    end else if (mem_xlat != XL_MISS) begin
                        d.st    = ST_IDLE;
                        d.fault = 1'b1;
                    end
                end
            end
            ST_HI: begin
                if (mem_ack) begin
                    if (mem_xlat == XL_OK) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.res  = q.store ? '0 : load_res;
                    end else if (mem_xlat != XL_MISS) begin
                        d.st      = ST_IDLE;
                        d.restart = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req       = (q.st != ST_IDLE);
    assign mem_we        = q.store;
    assign mem_addr      = (q.st == ST_HI) ? base_addr + ADDR_W'(LANES) : base_addr;
    assign mem_be        = (q.st == ST_HI) ? be_hi : be_lo;
    assign mem_wdata     = (q.st == ST_HI) ? wd_hi : wd_lo;
    assign done          = q.done;
    assign rsp_rdata     = q.res;
    assign rsp_restart   = q.restart;
    assign rsp_fault     = q.fault;
    assign rsp_align_exc = q.alx;
endmodule

// File: rtl/lss_split_chk.sv
module lss_split_chk #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    localparam int DW    = 8 * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_multi,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_be,
    input logic [1:0]        mem_xlat,
    input logic              done,
    input logic              rsp_restart,
    input logic              rsp_fault,
    input logic              rsp_align_exc
);
    a_r10_single_end: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, rsp_restart, rsp_fault, rsp_align_exc}));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r9_align_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_multi && (req_addr[1:0] != 2'b00))
        |=> (rsp_align_exc && !mem_req));

    a_r2_second_next_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req && mem_ack && (mem_xlat == 2'd0)))
        |-> (mem_addr == $past(mem_addr) + ADDR_W'(LANES)));

    a_r6_miss_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_xlat == 2'd1))
        |=> (mem_req && $stable(mem_addr) && $stable(mem_be)));

    a_r8_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_xlat == 2'd2))
        |=> (!mem_req && (rsp_fault || rsp_restart)));

    a_r3_enables_present: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be != '0));
endmodule

bind lss_split_unit lss_split_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lss_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_multi     (req_multi),
    .mem_req       (mem_req),
    .mem_ack       (mem_ack),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .mem_xlat      (mem_xlat),
    .done          (done),
    .rsp_restart   (rsp_restart),
    .rsp_fault     (rsp_fault),
    .rsp_align_exc (rsp_align_exc)
);

// File: tb/test_lss_split_unit.sv
module test_lss_split_unit;
    localparam int AW = 16;
    localparam int LN = 8;
    localparam int DW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_store = 1'b0;
    logic          req_rev = 1'b0;
    logic          req_multi = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          mem_req, mem_ack, mem_we;
    logic [AW-1:0] mem_addr;
    logic [LN-1:0] mem_be;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [1:0]    mem_xlat;
    logic          done, rsp_restart, rsp_fault, rsp_align_exc;
    logic [DW-1:0] rsp_rdata;

    lss_split_unit #(.ADDR_W(AW), .LANES(LN)) i_lss_split_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_store(req_store),
        .req_rev(req_rev), .req_multi(req_multi), .req_wdata(req_wdata),
        .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_xlat(mem_xlat), .done(done), .rsp_rdata(rsp_rdata),
        .rsp_restart(rsp_restart), .rsp_fault(rsp_fault), .rsp_align_exc(rsp_align_exc)
    );

    // memory model: 64 bytes, always acknowledges, translation from a script
    logic [7:0]  mem [64];
    logic [7:0]  ref_mem [64];
    logic [1:0]  xscript [8];
    int unsigned acc_cnt = 0;
    int unsigned base = 0;

    assign mem_ack  = mem_req;
    assign mem_xlat = xscript[3'(acc_cnt - base)];
    always_comb begin
        for (int b = 0; b < 8; b++)
            mem_rdata[8*b +: 8] = mem[{mem_addr[5:3], 3'(7 - b)}];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (mem_req && mem_ack) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_xlat == 2'd0 && mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) mem[{mem_addr[5:3], 3'(7 - b)}] <= mem_wdata[8*b +: 8];
            end
        end
    end

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic clr_script();
        for (int i = 0; i < 8; i++) xscript[i] = 2'd0;
    endtask

    function automatic int nbytes_of(input logic [1:0] sz);
        return 1 << sz;
    endfunction

    function automatic logic [63:0] ref_load(input logic [5:0] a, input logic [1:0] sz,
                                            input bit rev);
        logic [63:0] v = '0;
        int n = nbytes_of(sz);
        for (int k = 0; k < n; k++) begin
            if (rev) v[8*k +: 8] = ref_mem[6'(a + k)];
            else     v[8*(n-1-k) +: 8] = ref_mem[6'(a + k)];
        end
        return v;
    endfunction

    task automatic ref_store(input logic [5:0] a, input logic [1:0] sz, input bit rev,
                             input logic [63:0] wd, input bit first_only);
        int n = nbytes_of(sz);
        for (int k = 0; k < n; k++) begin
            if (!first_only || (int'(a[2:0]) + k) < 8)
                ref_mem[6'(a + k)] = rev ? wd[8*k +: 8] : wd[8*(n-1-k) +: 8];
        end
    endtask

    function automatic bit mem_matches();
        for (int i = 0; i < 64; i++) if (mem[i] !== ref_mem[i]) return 1'b0;
        return 1'b1;
    endfunction

    // results of one request
    int unsigned r_acc, r_lat;
    logic r_done, r_rst, r_flt, r_alx;
    logic [63:0] r_data;
    bit r_ready_busy;

    task automatic run_req(input bit st, input bit rev, input bit multi, input logic [1:0] sz,
                           input logic [5:0] a, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_rev = rev; req_multi = multi;
        req_size = sz; req_addr = AW'(a); req_wdata = wd;
        base = acc_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        r_ready_busy = 1'b0;
        while (!(done || rsp_restart || rsp_fault || rsp_align_exc) && r_lat < 40) begin
            if (req_ready) r_ready_busy = 1'b1;
            @(negedge clk);
            r_lat++;
        end
        r_done = done; r_rst = rsp_restart; r_flt = rsp_fault; r_alx = rsp_align_exc;
        r_data = rsp_rdata;
        r_acc  = acc_cnt - base;
    endtask

    // vector: store, rev, size, addr, wdata
    localparam int NV = 12;
    localparam logic [73:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd3, 6'h00, 64'h0},
        {1'b0, 1'b0, 2'd2, 6'h0C, 64'h0},
        {1'b0, 1'b0, 2'd2, 6'h0E, 64'h0},
        {1'b0, 1'b0, 2'd3, 6'h13, 64'h0},
        {1'b0, 1'b0, 2'd1, 6'h07, 64'h0},
        {1'b0, 1'b0, 2'd0, 6'h25, 64'h0},
        {1'b1, 1'b0, 2'd3, 6'h1D, 64'h1122334455667788},
        {1'b1, 1'b1, 2'd1, 6'h2F, 64'h000000000000A1B2},
        {1'b0, 1'b1, 2'd3, 6'h1D, 64'h0},
        {1'b1, 1'b0, 2'd2, 6'h30, 64'hFFFFFFFFDEADBEEF},
        {1'b0, 1'b1, 2'd1, 6'h0B, 64'h0},
        {1'b1, 1'b0, 2'd0, 6'h3F, 64'h000000000000005A}
    };

    initial begin
        logic [63:0] exp;
        int unsigned exp_acc;
        clr_script();
        for (int i = 0; i < 64; i++) ref_mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready === 1'b1, "R11", "ready in reset", 64'(req_ready), 64'd1);
        chk(mem_req === 1'b0 && done === 1'b0 && rsp_restart === 1'b0, "R11",
            "idle outputs in reset", {62'd0, mem_req, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && mem_req === 1'b0, "R11", "idle after reset",
            {62'd0, req_ready, mem_req}, 64'd2);

        // table walk: R1 R2 R3 R4 R5 R10
        for (int v = 0; v < NV; v++) begin
            logic [73:0] e = VEC[v];
            logic [5:0] a = e[69:64];
            logic [1:0] sz = e[71:70];
            exp_acc = ((int'(a[2:0]) + nbytes_of(sz)) > 8) ? 2 : 1;
            exp = ref_load(a, sz, e[72]);
            run_req(e[73], e[72], 1'b0, sz, a, e[63:0]);
            chk(r_done === 1'b1, "R10", $sformatf("vec %0d ends with done", v), 64'(r_done), 64'd1);
            chk(r_acc == exp_acc, exp_acc == 2 ? "R2" : "R1",
                $sformatf("vec %0d access count", v), 64'(r_acc), 64'(exp_acc));
            chk(r_lat == exp_acc + 1, "R1", $sformatf("vec %0d latency", v),
                64'(r_lat), 64'(exp_acc + 1));
            chk(!r_ready_busy, "R10", $sformatf("vec %0d ready while busy", v), 64'(r_ready_busy), 64'd0);
            if (e[73]) begin
                ref_store(a, sz, e[72], e[63:0], 1'b0);
                chk(mem_matches(), e[72] ? "R5" : "R3", $sformatf("vec %0d memory image", v),
                    64'(a), 64'(a));
            end else begin
                chk(r_data === exp, e[72] ? "R5" : "R4", $sformatf("vec %0d load data", v),
                    r_data, exp);
            end
        end

        // R6: TLB misses stall, no restart
        xscript[0] = 2'd1; xscript[1] = 2'd1; xscript[2] = 2'd0; xscript[3] = 2'd1;
        exp = ref_load(6'h0E, 2'd2, 1'b0);
        run_req(1'b0, 1'b0, 1'b0, 2'd2, 6'h0E, 64'h0);
        clr_script();
        chk(r_done === 1'b1 && r_rst === 1'b0, "R6", "miss ends in done",
            {62'd0, r_done, r_rst}, 64'd2);
        chk(r_acc == 5, "R6", "miss reissue count", 64'(r_acc), 64'd5);
        chk(r_data === exp, "R6", "data after misses", r_data, exp);

        // R7: page fault on second portion of a store, then retry
        xscript[1] = 2'd2;
        run_req(1'b1, 1'b0, 1'b0, 2'd3, 6'h1A, 64'hC1C2C3C4C5C6C7C8);
        clr_script();
        chk(r_rst === 1'b1 && r_done === 1'b0, "R7", "restart pulse",
            {62'd0, r_rst, r_done}, 64'd2);
        chk(r_acc == 2, "R7", "accesses before restart", 64'(r_acc), 64'd2);
        ref_store(6'h1A, 2'd3, 1'b0, 64'hC1C2C3C4C5C6C7C8, 1'b1);
        chk(mem_matches(), "R7", "first half written only", 64'h1A, 64'h1A);
        run_req(1'b1, 1'b0, 1'b0, 2'd3, 6'h1A, 64'hC1C2C3C4C5C6C7C8);
        ref_store(6'h1A, 2'd3, 1'b0, 64'hC1C2C3C4C5C6C7C8, 1'b0);
        chk(r_done === 1'b1 && r_acc == 2, "R7", "retry completes",
            64'(r_acc), 64'd2);
        chk(mem_matches(), "R7", "memory after retry", 64'h1A, 64'h1A);

        // R8: page fault on first portion
        xscript[0] = 2'd2;
        run_req(1'b1, 1'b0, 1'b0, 2'd2, 6'h21, 64'h00000000EEEEEEEE);
        clr_script();
        chk(r_flt === 1'b1 && r_done === 1'b0 && r_rst === 1'b0, "R8", "fault pulse",
            {61'd0, r_flt, r_done, r_rst}, 64'd4);
        chk(r_acc == 1, "R8", "no second portion", 64'(r_acc), 64'd1);
        chk(mem_matches(), "R8", "memory untouched", 64'h21, 64'h21);

        // R9: multiple-word alignment
        run_req(1'b0, 1'b0, 1'b1, 2'd2, 6'h22, 64'h0);
        chk(r_alx === 1'b1 && r_done === 1'b0, "R9", "align exception",
            {62'd0, r_alx, r_done}, 64'd2);
        chk(r_acc == 0 && r_lat == 1, "R9", "no access, one cycle", 64'(r_acc), 64'd0);
        exp = ref_load(6'h24, 2'd2, 1'b0);
        run_req(1'b0, 1'b0, 1'b1, 2'd2, 6'h24, 64'h0);
        chk(r_done === 1'b1 && r_data === exp, "R9", "aligned multiple proceeds", r_data, exp);

        @(negedge clk);
        chk(done === 1'b0 && rsp_align_exc === 1'b0, "R10", "pulse lasts one cycle",
            {62'd0, done, rsp_align_exc}, 64'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule